// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block turns a parallel word into a serial bit stream. While the active-low load input is held low, every stage copies its matching parallel input. Once load goes high, each rising edge of a gated clock moves the contents one place from the first stage toward the last stage, and the serial input enters the first stage. The last stage is driven out in true and inverted form, so a downstream consumer can take either polarity.

The gated clock is the OR of two interchangeable inputs, `clk_a` and `clk_b`. Holding either one high stops shifting, so one of them can act as a clock inhibit. All pins are sampled on a single system clock. A small control state machine tracks the level of the gated clock and turns a low-to-high change into a one-cycle shift command.

The control machine has four states. `ST_SYNC` is entered on reset. `ST_LOADING` is held while load is low. `ST_GATE_LOW` and `ST_GATE_HIGH` record the last sampled gate level.

The transitions are as follows:
- Any state goes to `ST_LOADING` when load is sampled low.
- `ST_SYNC` and `ST_LOADING` go to `ST_GATE_HIGH` or `ST_GATE_LOW` once load is high. The level is adopted with no shift.
- `ST_GATE_LOW` goes to `ST_GATE_HIGH` on a high gate, and that transition issues a shift.
- `ST_GATE_HIGH` goes to `ST_GATE_LOW` on a low gate.

Top module: `piso_shift_reg`

## Requirements
- R1: A synchronous active-high `rst` clears every stage to zero, so `q_last` reads 0 and `q_last_n` reads 1.
- R2: While `load_n` is sampled low, stage i takes `par_in[i]`, whatever the levels of `clk_a`, `clk_b` and `ser_in`. Stage 0 is the first stage and stage W-1 is the last.
- R3: With `load_n` high, a low-to-high change of the gated clock shifts the register once. Stage 0 takes `ser_in` and stage i takes the old stage i-1.
- R4: The gated clock is `clk_a | clk_b`, and the two inputs are interchangeable. While either one is held high, toggling the other causes no shift.
- R5: With `load_n` high and no rising gate edge, all stages keep their values.
- R6: `q_last` equals the last stage, and `q_last_n` is its complement.
- R7: Raising the inhibit input while the other clock input is low counts as a rising gate edge and causes one shift.
- R8: A sampled low `load_n` wins over a gate edge sampled in the same cycle. No shift happens in the cycle in which load is released, even if the gate rises then.
- R9: A gate that is already high when reset is released is not taken as an edge.
- R10: Every input is sampled on one system clock edge and takes effect on the stages at the next edge, a latency of two edges from pin to `stages_dbg`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low parallel load |
| clk_a | input | 1 | Gated clock input, interchangeable with clk_b |
| clk_b | input | 1 | Gated clock input, interchangeable with clk_a, usable as inhibit |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | W | Parallel data, bit i to stage i |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Complement of last stage |
| stages_dbg | output | W | All stages, bit i is stage i |

## Verification
Two functions can fall in the same sampled cycle: a parallel load and a rising gate edge. Load can also be released in the same cycle as a rising gate edge. The bench provokes both cases by driving `load_n` low, or raising it, on the same cycle that `clk_a` rises. A scoreboard model then judges the result: on the first collision the register must show the parallel word, and on the second it must stay unshifted. A high gate held through the release of reset is judged the same way.

// File: rtl/piso_pkg.sv
package piso_pkg;

    typedef enum logic [1:0] {
        ST_SYNC,
        ST_LOADING,
        ST_GATE_LOW,
        ST_GATE_HIGH
    } ctrl_state_t;

    typedef enum logic [1:0] {
        OP_HOLD,
        OP_LOAD,
        OP_SHIFT
    } stage_op_t;

endpackage

// File: rtl/piso_sampler.sv
module piso_sampler #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         load_n,
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic         load_n_q,
    output logic         gate_q,
    output logic         ser_q,
    output logic [W-1:0] par_q
);
    // Plain input registers; they run through reset so the gate level is
    // already valid when the control machine leaves ST_SYNC.
    always_ff @(posedge clk) begin
        load_n_q <= load_n;
        gate_q   <= clk_a | clk_b;
        ser_q    <= ser_in;
        par_q    <= par_in;
    end
endmodule

// File: rtl/piso_ctrl.sv
module piso_ctrl
    import piso_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      load_n_q,
    input  logic      gate_q,
    output stage_op_t op
);
    ctrl_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_SYNC;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!load_n_q) begin
            state_d = ST_LOADING;
        end else begin
            unique case (state_q)
                ST_SYNC, ST_LOADING: state_d = gate_q ? ST_GATE_HIGH : ST_GATE_LOW;
                ST_GATE_LOW:         state_d = gate_q ? ST_GATE_HIGH : ST_GATE_LOW;
                ST_GATE_HIGH:        state_d = gate_q ? ST_GATE_HIGH : ST_GATE_LOW;
                default:             state_d = ST_SYNC;
            endcase
        end
    end

    always_comb begin
        op = OP_HOLD;
        if (!load_n_q) begin
            op = OP_LOAD;
        end else begin
            unique case (state_q)
                ST_GATE_LOW:                      op = gate_q ? OP_SHIFT : OP_HOLD;
                ST_SYNC, ST_LOADING, ST_GATE_HIGH: op = OP_HOLD;
                default:                          op = OP_HOLD;
            endcase
        end
    end
endmodule

// File: rtl/piso_stages.sv
module piso_stages
    import piso_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  stage_op_t    op,
    input  logic         ser_q,
    input  logic [W-1:0] par_q,
    output logic [W-1:0] stages
);
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic shift_src;
        if (i == 0) begin : g_head
            assign shift_src = ser_q;
        end else begin : g_body
            assign shift_src = stages[i-1];
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                stages[i] <= 1'b0;
            end else begin
                unique case (op)
                    OP_LOAD:  stages[i] <= par_q[i];
                    OP_SHIFT: stages[i] <= shift_src;
                    default:  stages[i] <= stages[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/piso_shift_reg.sv
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_n,
    input  logic         clk_a,
    input  logic         clk_b,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic         q_last,
    output logic         q_last_n,
    output logic [W-1:0] stages_dbg
);
    localparam int LAST = W - 1;

    logic         load_n_q, gate_q, ser_q;
    logic [W-1:0] par_q;
    logic [W-1:0] stages;
    stage_op_t    op;

    piso_sampler #(.W(W)) u_sampler (
        .clk(clk), .load_n(load_n), .clk_a(clk_a), .clk_b(clk_b),
        .ser_in(ser_in), .par_in(par_in),
        .load_n_q(load_n_q), .gate_q(gate_q), .ser_q(ser_q), .par_q(par_q)
    );

    piso_ctrl u_ctrl (
        .clk(clk), .rst(rst), .load_n_q(load_n_q), .gate_q(gate_q), .op(op)
    );

    piso_stages #(.W(W)) u_stages (
        .clk(clk), .rst(rst), .op(op), .ser_q(ser_q), .par_q(par_q),
        .stages(stages)
    );

    assign q_last     = stages[LAST];
    assign q_last_n   = ~stages[LAST];
    assign stages_dbg = stages;
endmodule

// File: rtl/piso_shift_reg_chk.sv
module piso_shift_reg_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         load_n,
    input logic         clk_a,
    input logic         clk_b,
    input logic         ser_in,
    input logic [W-1:0] par_in,
    input logic [W-1:0] stages_dbg
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> stages_dbg == '0); // R1

    AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load_n, 2)) |-> stages_dbg == $past(par_in, 2)); // R2

    AST_INHIBIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_n, 2) && $past(clk_a | clk_b, 2) && $past(clk_a | clk_b, 3))
        |-> $stable(stages_dbg)); // R4

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(load_n, 2) && $past(load_n, 3)
         && $past(clk_a | clk_b, 2) && !$past(clk_a | clk_b, 3))
        |-> stages_dbg == {$past(stages_dbg[W-2:0]), $past(ser_in, 2)}); // R3

    AST_RELEASE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(load_n, 2) && !$past(load_n, 3)) |-> $stable(stages_dbg)); // R8
endmodule

bind piso_shift_reg piso_shift_reg_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .load_n(load_n), .clk_a(clk_a), .clk_b(clk_b),
    .ser_in(ser_in), .par_in(par_in), .stages_dbg(stages_dbg)
);

// File: tb/piso_shift_reg_tb.sv
module piso_shift_reg_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic         clk_a = 1'b0;
    logic         clk_b = 1'b0;
    logic         ser_in = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         q_last, q_last_n;
    logic [W-1:0] stages_dbg;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        logic [W-1:0] val;
        string        req;
    } exp_t;
    exp_t sb_q[$];

    // Reference model: history of sampled pins and tracking of gate level.
    typedef enum int {M_SYNC, M_LOAD, M_LOW, M_HIGH} mst_t;
    mst_t         m_st = M_SYNC;
    logic [W-1:0] m_stages = '0;
    logic         p_ld = 1'b1, p_gate = 1'b0, p_ser = 1'b0;
    logic [W-1:0] p_par = '0;

    always #4 clk = ~clk;

    piso_shift_reg #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .load_n(load_n), .clk_a(clk_a), .clk_b(clk_b),
        .ser_in(ser_in), .par_in(par_in), .q_last(q_last), .q_last_n(q_last_n),
        .stages_dbg(stages_dbg)
    );

    task automatic step(input logic r, input logic ld, input logic a, input logic b,
                        input logic s, input logic [W-1:0] p, input string req);
        exp_t e;
        @(negedge clk);
        rst = r; load_n = ld; clk_a = a; clk_b = b; ser_in = s; par_in = p;
        // The values sampled one edge earlier (p_*) act at the coming edge (R10).
        if (r) begin
            m_stages = '0; m_st = M_SYNC;
        end else if (!p_ld) begin
            m_stages = p_par; m_st = M_LOAD;
        end else begin
            case (m_st)
                M_LOW: if (p_gate) begin
                    m_stages = {m_stages[W-2:0], p_ser}; m_st = M_HIGH;
                end
                M_HIGH: if (!p_gate) m_st = M_LOW;
                default: m_st = p_gate ? M_HIGH : M_LOW;
            endcase
        end
        p_ld = ld; p_gate = a | b; p_ser = s; p_par = p;
        e.val = m_stages; e.req = req;
        sb_q.push_back(e);
    endtask

    task automatic run(input logic ld, input logic a, input logic b,
                       input logic s, input logic [W-1:0] p, input string req);
        step(1'b0, ld, a, b, s, p, req);
    endtask

    // Monitor: compares shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                if (stages_dbg !== e.val) begin
                    failures++;
                    $display("FAIL %s stages actual=%h expected=%h", e.req, stages_dbg, e.val);
                end
                checks++;
                if (q_last !== e.val[W-1] || q_last_n !== ~e.val[W-1]) begin
                    failures++;
                    $display("FAIL R6 outputs actual=%b/%b expected=%b/%b",
                             q_last, q_last_n, e.val[W-1], ~e.val[W-1]);
                end
            end
        end
    end

    initial begin
        // R1/R9: reset with clk_a high; the held-high gate after release must not shift.
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, '0, "R1");
        for (int i = 0; i < 3; i++) run(1'b1, 1'b1, 1'b0, 1'b1, '0, "R9");
        // R2: load while clocks and serial input toggle.
        run(1'b0, 1'b0, 1'b0, 1'b1, 8'hA5, "R2");
        run(1'b0, 1'b1, 1'b0, 1'b0, 8'hA5, "R2");
        run(1'b0, 1'b0, 1'b1, 1'b1, 8'h3C, "R2");
        run(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R2");
        // R3/R6: shift with clk_a, clk_b low, serial pattern 1,0,1,1.
        for (int i = 0; i < 4; i++) begin
            run(1'b1, 1'b1, 1'b0, (i != 1), '0, "R3");
            run(1'b1, 1'b0, 1'b0, 1'b0, '0, "R3");
        end
        // R4: clk_b held high inhibits toggling clk_a.
        run(1'b1, 1'b0, 1'b1, 1'b0, '0, "R4");
        for (int i = 0; i < 3; i++) begin
            run(1'b1, 1'b1, 1'b1, 1'b1, '0, "R4");
            run(1'b1, 1'b0, 1'b1, 1'b1, '0, "R4");
        end
        // R4: roles swapped, clk_a low and clk_b toggles as clock.
        run(1'b1, 1'b0, 1'b0, 1'b0, '0, "R4");
        run(1'b1, 1'b0, 1'b1, 1'b1, '0, "R4");
        run(1'b1, 1'b0, 1'b0, 1'b0, '0, "R4");
        // R5: no edges, everything held.
        for (int i = 0; i < 4; i++) run(1'b1, 1'b0, 1'b0, 1'b1, 8'hFF, "R5");
        // R7: raising the inhibit while clock low makes one shift.
        run(1'b1, 1'b0, 1'b1, 1'b1, '0, "R7");
        run(1'b1, 1'b1, 1'b1, 1'b1, '0, "R7");
        run(1'b1, 1'b1, 1'b0, 1'b0, '0, "R7");
        // R8: load together with a rising edge, then release on a rising edge.
        run(1'b1, 1'b0, 1'b0, 1'b0, '0, "R8");
        run(1'b0, 1'b1, 1'b0, 1'b1, 8'h96, "R8");
        run(1'b0, 1'b0, 1'b0, 1'b1, 8'h96, "R8");
        run(1'b1, 1'b1, 1'b0, 1'b1, '0, "R8");
        run(1'b1, 1'b1, 1'b0, 1'b0, '0, "R8");
        // R10 and R6: clock the whole word out with ones filling in.
        for (int i = 0; i < W; i++) begin
            run(1'b1, 1'b0, 1'b0, 1'b1, '0, "R10");
            run(1'b1, 1'b1, 1'b0, 1'b1, '0, "R10");
        end
        for (int i = 0; i < 3; i++) run(1'b1, 1'b0, 1'b0, 1'b0, '0, "R10");
        // Reset again after data (R1).
        for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, "R1");
        repeat (3) @(posedge clk);
        #3;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule